// File: doc/BRIEF.md
# Programmable Logic Cell

A model of one programmable cell from a reconfigurable logic array. A 16-entry truth table turns four data lines into any Boolean function. A carry-select arithmetic path can take the table's place. It adds or subtracts one bit, and the direction is chosen while the cell runs. The path computes two carry chains side by side, one for each assumed block carry-in, and a shared block carry-in picks the live chain.

The cell holds one storage register. Per-cell configuration inputs choose:
- which of two clocks drives the register, and which of two enables gates it;
- which of two asynchronous clear lines acts on it, and whether clearing is used at all;
- whether the preset line sets the register or loads it asynchronously;
- where the register data comes from: the function result, the previous cell's chain output, or a data line directly (packed use).

Synchronous clear and synchronous load act on enabled edges. A bypass switch routes either the function result or the register to the cell output. The register value always goes on to the next cell's chain input.

Configuration inputs are static: they are held steady while the register is clocked. The surrounding fabric and the loading of configuration bits are outside this block.

Top module: `logic_cell`

## Requirements
- R1: With arith_i=0 and bypass_i=1, route_o equals lut_mask_i bit number data_i, where data_i is read as an unsigned number with data_i[0] as its least significant bit.
- R2: With bypass_i=0, route_o equals the register value, and chain_o always equals the register value.
- R3: With arith_i=1, let a=data_i[0] and b=data_i[1]^addnsub_i, where addnsub_i=1 means subtract. The selected carry is cin1_i when blk_cin_i=1 and cin0_i otherwise. The function result is a^b^(selected carry). cout0_o is the majority of a, b and cin0_i; cout1_o is the majority of a, b and cin1_i. Chaining eight cells with the first cell's cin0_i=0, cin1_i=1 and blk_cin_i=addnsub_i yields A+B, or A-B with carry-out set when A>=B.
- R4: The register is clocked by clk_i[clk_sel_i] and updates only when ena_i[ena_sel_i]=1. Otherwise it holds, and edges of the unselected clock have no effect.
- R5: On an enabled edge, sclr_i=1 clears the register and overrides sload_i. With sclr_i=0 and sload_i=1, the register takes data_i[2] instead of its selected source.
- R6: rst_ni=0, or clr_use_i=1 together with aclr_i[clr_sel_i]=1, clears the register at once without a clock. The unselected clear line, and any clear line while clr_use_i=0, has no effect.
- R7: While apre_i=1, the register is set to 1 at once (apre_mode_i=0) or takes data_i[3] (apre_mode_i=1). An active clear from R6 wins over apre_i.
- R8: With dsrc_i=1, the register captures chain_i on an enabled edge.
- R9: With dsrc_i=2 (packed use), the register captures data_i[2], while route_o under bypass_i=1 still shows the table result.
- R10: With dsrc_i=0 or 3, the register captures the function result (table or arithmetic).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Chip-wide asynchronous reset, active low |
| clk_i | input | N_CLK (2) | Shared clocks |
| ena_i | input | N_ENA (2) | Shared clock enables |
| aclr_i | input | N_CLR (2) | Shared asynchronous clears, active high |
| apre_i | input | 1 | Asynchronous preset / load line, active high |
| sclr_i | input | 1 | Shared synchronous clear |
| sload_i | input | 1 | Shared synchronous load |
| data_i | input | K (4) | Function inputs |
| chain_i | input | 1 | Register chain from the previous cell |
| addnsub_i | input | 1 | 1 = subtract, 0 = add |
| cin0_i | input | 1 | Carry-in assuming block carry-in 0 |
| cin1_i | input | 1 | Carry-in assuming block carry-in 1 |
| blk_cin_i | input | 1 | Block carry-in, selects between the chains |
| lut_mask_i | input | 2**K (16) | Truth table configuration |
| arith_i | input | 1 | 1 = arithmetic result replaces table |
| bypass_i | input | 1 | 1 = output driven by function result |
| dsrc_i | input | 2 | Register data source: 0 function, 1 chain, 2 packed data_i[2] |
| clk_sel_i | input | CSW (1) | Clock select |
| ena_sel_i | input | ESW (1) | Enable select |
| clr_sel_i | input | RSW (1) | Asynchronous clear select |
| clr_use_i | input | 1 | Enables the asynchronous clear lines |
| apre_mode_i | input | 1 | 0 = preset to 1, 1 = asynchronous load of data_i[3] |
| route_o | output | 1 | Cell routing output |
| chain_o | output | 1 | Register chain output |
| cout0_o | output | 1 | Carry-out for block carry-in 0 |
| cout1_o | output | 1 | Carry-out for block carry-in 1 |

## Verification
The bench builds the cell with its default parameters: four table inputs and two of each shared clock, enable and clear line. With two of each line, both values of every select bit can be reached, and an unselected line can be shown to have no effect. All 16 input codes are run through three different truth tables. An eight-cell ripple chain of default cells exercises both carry chains and the block carry-in together across many operand pairs, with carries that run the full length of the chain.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    DSRC_FUNC  = 2'd0,
    DSRC_CHAIN = 2'd1,
    DSRC_PACK  = 2'd2,
    DSRC_ALT   = 2'd3
  } dsrc_e;
endpackage

// File: rtl/lc_func.sv
module lc_func #(
  parameter int K = 4,
  localparam int LUT_BITS = 1 << K
) (
  input  logic [K-1:0]        data_i,
  input  logic [LUT_BITS-1:0] lut_mask_i,
  input  logic                arith_i,
  input  logic                addnsub_i,
  input  logic                cin0_i,
  input  logic                cin1_i,
  input  logic                blk_cin_i,
  output logic                func_o,
  output logic                lut_o,
  output logic                cout0_o,
  output logic                cout1_o
);
  logic op_a, op_b, cin_sel;

  always_comb begin
    op_a    = data_i[0];
    op_b    = data_i[1] ^ addnsub_i;
    cin_sel = blk_cin_i ? cin1_i : cin0_i;
    lut_o   = lut_mask_i[data_i];
    func_o  = arith_i ? (op_a ^ op_b ^ cin_sel) : lut_o;
    cout0_o = (op_a & op_b) | (op_a & cin0_i) | (op_b & cin0_i);
    cout1_o = (op_a & op_b) | (op_a & cin1_i) | (op_b & cin1_i);
  end

  // carry with assumed 1 never below carry with assumed 0
  always_comb begin
    if (!cin0_i || cin1_i)
      a_r3_carry_order: assert (!cout0_o || cout1_o);
  end
endmodule

// File: rtl/lc_ff.sv
module lc_ff #(
  parameter int N_CLK = 2,
  parameter int N_ENA = 2,
  parameter int N_CLR = 2,
  localparam int CSW = (N_CLK > 1) ? $clog2(N_CLK) : 1,
  localparam int ESW = (N_ENA > 1) ? $clog2(N_ENA) : 1,
  localparam int RSW = (N_CLR > 1) ? $clog2(N_CLR) : 1
) (
  input  logic             rst_ni,
  input  logic [N_CLK-1:0] clk_i,
  input  logic [N_ENA-1:0] ena_i,
  input  logic [N_CLR-1:0] aclr_i,
  input  logic [CSW-1:0]   clk_sel_i,
  input  logic [ESW-1:0]   ena_sel_i,
  input  logic [RSW-1:0]   clr_sel_i,
  input  logic             clr_use_i,
  input  logic             apre_i,
  input  logic             apre_mode_i,
  input  logic             aload_d_i,
  input  logic             sclr_i,
  input  logic             sload_i,
  input  logic             sload_d_i,
  input  logic             d_i,
  output logic             q_o
);
  logic reg_clk, reg_ena, clr_n;

  always_comb begin
    reg_clk = clk_i[clk_sel_i];
    reg_ena = ena_i[ena_sel_i];
    clr_n   = rst_ni & ~(clr_use_i & aclr_i[clr_sel_i]);
  end

  // clear > preset/load > enable > sync clear > sync load > data
  always_ff @(posedge reg_clk or negedge clr_n or posedge apre_i) begin
    if (!clr_n)          q_o <= 1'b0;
    else if (apre_i)     q_o <= apre_mode_i ? aload_d_i : 1'b1;
    else if (reg_ena) begin
      if (sclr_i)        q_o <= 1'b0;
      else if (sload_i)  q_o <= sload_d_i;
      else               q_o <= d_i;
    end
  end

  a_r4_hold_when_disabled: assert property (@(posedge reg_clk) disable iff (!rst_ni)
    (clr_n && !apre_i && !reg_ena) |=> ($stable(q_o) || !clr_n || apre_i));

  a_r5_sync_clear: assert property (@(posedge reg_clk) disable iff (!rst_ni)
    (clr_n && !apre_i && reg_ena && sclr_i) |=> (!q_o || !clr_n || apre_i));

  a_r5_sync_load: assert property (@(posedge reg_clk) disable iff (!rst_ni)
    (clr_n && !apre_i && reg_ena && !sclr_i && sload_i)
      |=> (q_o == $past(sload_d_i) || !clr_n || apre_i));
endmodule

// File: rtl/logic_cell.sv
module logic_cell #(
  parameter int K     = 4,
  parameter int N_CLK = 2,
  parameter int N_ENA = 2,
  parameter int N_CLR = 2,
  localparam int LUT_BITS = 1 << K,
  localparam int CSW = (N_CLK > 1) ? $clog2(N_CLK) : 1,
  localparam int ESW = (N_ENA > 1) ? $clog2(N_ENA) : 1,
  localparam int RSW = (N_CLR > 1) ? $clog2(N_CLR) : 1
) (
  input  logic                rst_ni,
  input  logic [N_CLK-1:0]    clk_i,
  input  logic [N_ENA-1:0]    ena_i,
  input  logic [N_CLR-1:0]    aclr_i,
  input  logic                apre_i,
  input  logic                sclr_i,
  input  logic                sload_i,
  input  logic [K-1:0]        data_i,
  input  logic                chain_i,
  input  logic                addnsub_i,
  input  logic                cin0_i,
  input  logic                cin1_i,
  input  logic                blk_cin_i,
  input  logic [LUT_BITS-1:0] lut_mask_i,
  input  logic                arith_i,
  input  logic                bypass_i,
  input  logic [1:0]          dsrc_i,
  input  logic [CSW-1:0]      clk_sel_i,
  input  logic [ESW-1:0]      ena_sel_i,
  input  logic [RSW-1:0]      clr_sel_i,
  input  logic                clr_use_i,
  input  logic                apre_mode_i,
  output logic                route_o,
  output logic                chain_o,
  output logic                cout0_o,
  output logic                cout1_o
);
  import lc_pkg::*;

  logic func_res, lut_res, reg_d, reg_q;

  lc_func #(.K(K)) u_func (
    .data_i    (data_i),
    .lut_mask_i(lut_mask_i),
    .arith_i   (arith_i),
    .addnsub_i (addnsub_i),
    .cin0_i    (cin0_i),
    .cin1_i    (cin1_i),
    .blk_cin_i (blk_cin_i),
    .func_o    (func_res),
    .lut_o     (lut_res),
    .cout0_o   (cout0_o),
    .cout1_o   (cout1_o)
  );

  always_comb begin
    unique case (dsrc_e'(dsrc_i))
      DSRC_CHAIN: reg_d = chain_i;
      DSRC_PACK:  reg_d = data_i[2];
      default:    reg_d = func_res;
    endcase
  end

  lc_ff #(.N_CLK(N_CLK), .N_ENA(N_ENA), .N_CLR(N_CLR)) u_ff (
    .rst_ni     (rst_ni),
    .clk_i      (clk_i),
    .ena_i      (ena_i),
    .aclr_i     (aclr_i),
    .clk_sel_i  (clk_sel_i),
    .ena_sel_i  (ena_sel_i),
    .clr_sel_i  (clr_sel_i),
    .clr_use_i  (clr_use_i),
    .apre_i     (apre_i),
    .apre_mode_i(apre_mode_i),
    .aload_d_i  (data_i[3]),
    .sclr_i     (sclr_i),
    .sload_i    (sload_i),
    .sload_d_i  (data_i[2]),
    .d_i        (reg_d),
    .q_o        (reg_q)
  );

  assign route_o = bypass_i ? func_res : reg_q;
  assign chain_o = reg_q;

  always_comb begin
    if (rst_ni && bypass_i && !arith_i)
      a_r1_table_lookup: assert (route_o == lut_res);
    if (!bypass_i)
      a_r2_registered_out: assert (route_o == chain_o);
  end
endmodule

// File: tb/logic_cell_test.sv
module logic_cell_test;
  typedef struct {
    string      req;
    int         kind;  // 0 route_o, 1 chain_o, 2 ripple {carry,sum}
    logic [8:0] exp;
  } item_t;

  item_t sb[$];
  event  chk_ev;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  logic [1:0]  clk = '0;
  bit          c1_on = 1;
  logic        rst_ni = 0;
  logic [1:0]  ena = 2'b11, aclr = '0;
  logic        apre = 0, sclr = 0, sload = 0, chain_in = 0;
  logic [3:0]  data = '0;
  logic [15:0] mask = 16'h6996;
  logic        bypass = 0, apre_mode = 0, clk_sel = 0, ena_sel = 0, clr_sel = 0, clr_use = 1;
  logic [1:0]  dsrc = 2'd0;
  logic        route, chain_out, co0, co1;

  always #10 clk[0] = ~clk[0];
  always #17 clk[1] = c1_on ? ~clk[1] : 1'b0;

  logic_cell uut (
    .rst_ni(rst_ni), .clk_i(clk), .ena_i(ena), .aclr_i(aclr), .apre_i(apre),
    .sclr_i(sclr), .sload_i(sload), .data_i(data), .chain_i(chain_in),
    .addnsub_i(1'b0), .cin0_i(1'b0), .cin1_i(1'b1), .blk_cin_i(1'b0),
    .lut_mask_i(mask), .arith_i(1'b0), .bypass_i(bypass), .dsrc_i(dsrc),
    .clk_sel_i(clk_sel), .ena_sel_i(ena_sel), .clr_sel_i(clr_sel),
    .clr_use_i(clr_use), .apre_mode_i(apre_mode),
    .route_o(route), .chain_o(chain_out), .cout0_o(co0), .cout1_o(co1)
  );

  // eight-cell ripple chain in arithmetic mode
  logic [7:0] op_a = '0, op_b = '0, sum;
  logic       sub = 0;
  logic [8:0] c0, c1;
  logic       last_carry;
  assign c0[0] = 1'b0;
  assign c1[0] = 1'b1;
  assign last_carry = sub ? c1[8] : c0[8];

  for (genvar i = 0; i < 8; i++) begin : g_add
    logic unused_chain;
    logic_cell u_add (
      .rst_ni(rst_ni), .clk_i(clk), .ena_i(2'b11), .aclr_i(2'b00), .apre_i(1'b0),
      .sclr_i(1'b0), .sload_i(1'b0), .data_i({2'b00, op_b[i], op_a[i]}), .chain_i(1'b0),
      .addnsub_i(sub), .cin0_i(c0[i]), .cin1_i(c1[i]), .blk_cin_i(sub),
      .lut_mask_i(16'h0000), .arith_i(1'b1), .bypass_i(1'b1), .dsrc_i(2'd0),
      .clk_sel_i(1'b0), .ena_sel_i(1'b0), .clr_sel_i(1'b0),
      .clr_use_i(1'b0), .apre_mode_i(1'b0),
      .route_o(sum[i]), .chain_o(unused_chain), .cout0_o(c0[i+1]), .cout1_o(c1[i+1])
    );
  end

  task automatic expect_val(input string req, input int kind, input logic [8:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic tick(input int sel);
    @(posedge clk[sel]);
    #2;
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      item_t it;
      logic [8:0] got;
      @(chk_ev);
      while (sb.size() > 0) begin
        it = sb.pop_front();
        case (it.kind)
          0:       got = {8'd0, route};
          1:       got = {8'd0, chain_out};
          default: got = {last_carry, sum};
        endcase
        n_chk++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] masks [3];
    logic [7:0]  pa [10];
    logic [7:0]  pb [10];
    masks[0] = 16'h6996; masks[1] = 16'h8000; masks[2] = 16'hC35A;
    pa[0]=0;   pb[0]=0;   pa[1]=255; pb[1]=1;   pa[2]=100; pb[2]=55;
    pa[3]=200; pb[3]=100; pa[4]=0;   pb[4]=1;   pa[5]=170; pb[5]=85;
    pa[6]=37;  pb[6]=37;  pa[7]=1;   pb[7]=255; pa[8]=128; pb[8]=128;
    pa[9]=15;  pb[9]=240;

    #5 expect_val("R6 reset", 1, 9'd0);
    repeat (2) @(posedge clk[0]);
    #2 rst_ni = 1;

    // R1 exhaustive table
    bypass = 1;
    for (int m = 0; m < 3; m++) begin
      mask = masks[m];
      for (int v = 0; v < 16; v++) begin
        data = v[3:0];
        #1 expect_val("R1 table", 0, {8'd0, mask[v]});
      end
    end
    mask = 16'h6996;

    // R2 / R10 registered function result
    bypass = 0; data = 4'b0001;
    tick(0);
    expect_val("R2 route=reg", 0, 9'd1);
    expect_val("R10 func capture", 1, 9'd1);
    dsrc = 2'd3; data = 4'b0011;
    tick(0);
    expect_val("R10 dsrc3 capture", 1, 9'd0);
    dsrc = 2'd0; data = 4'b0001;
    tick(0);

    // R4 enable select
    ena_sel = 1; ena = 2'b01; data = 4'b0000;
    tick(0);
    expect_val("R4 disabled hold", 1, 9'd1);
    ena = 2'b10;
    tick(0);
    expect_val("R4 enable1 update", 1, 9'd0);
    ena_sel = 0; ena = 2'b11;

    // R4 clock select
    c1_on = 0;
    @(negedge clk[0]);
    wait (clk[1] == 1'b0);
    clk_sel = 1; data = 4'b0001;
    tick(0); tick(0);
    expect_val("R4 unselected clock ignored", 1, 9'd0);
    c1_on = 1;
    tick(1);
    expect_val("R4 clock1 update", 1, 9'd1);
    c1_on = 0;
    wait (clk[1] == 1'b0);
    @(negedge clk[0]);
    clk_sel = 0;
    tick(0);

    // R5 sync load / clear
    sload = 1; data = 4'b0001;
    tick(0);
    expect_val("R5 sload data2=0", 1, 9'd0);
    data = 4'b0101;
    tick(0);
    expect_val("R5 sload data2=1", 1, 9'd1);
    sclr = 1;
    tick(0);
    expect_val("R5 sclr over sload", 1, 9'd0);
    sclr = 0; sload = 0; data = 4'b0001;
    tick(0); tick(0);

    // R6 async clear
    aclr = 2'b10; #3;
    expect_val("R6 unselected clear ignored", 1, 9'd1);
    aclr = 2'b01; #3;
    expect_val("R6 selected clear", 1, 9'd0);
    aclr = 2'b00;
    tick(0);
    clr_use = 0; aclr = 2'b01; #3;
    expect_val("R6 clear unused ignored", 1, 9'd1);
    aclr = 2'b00; clr_use = 1; clr_sel = 1;
    tick(0);
    aclr = 2'b10; #3;
    expect_val("R6 clear line1", 1, 9'd0);
    aclr = 2'b00; clr_sel = 0; data = 4'b0000;
    tick(0);

    // R7 async preset / load
    apre_mode = 0; apre = 1; #3; apre = 0; #1;
    expect_val("R7 preset", 1, 9'd1);
    tick(0);
    expect_val("R7 preset then clock", 1, 9'd0);
    apre_mode = 1; data = 4'b1000;
    apre = 1; #3; apre = 0; #1;
    expect_val("R7 aload data3=1", 1, 9'd1);
    data = 4'b0000;
    apre = 1; #3; apre = 0; #1;
    expect_val("R7 aload data3=0", 1, 9'd0);
    tick(0);
    apre_mode = 0; aclr = 2'b01; apre = 1; #3;
    expect_val("R7 clear wins", 1, 9'd0);
    apre = 0; #1; aclr = 2'b00;
    tick(0);

    // R8 chain source
    dsrc = 2'd1; chain_in = 1; data = 4'b0000;
    tick(0);
    expect_val("R8 chain=1", 1, 9'd1);
    chain_in = 0;
    tick(0);
    expect_val("R8 chain=0", 1, 9'd0);

    // R9 packed
    dsrc = 2'd2; bypass = 1; data = 4'b0110;
    tick(0);
    expect_val("R9 packed reg", 1, 9'd1);
    expect_val("R9 packed route table", 0, 9'd0);
    dsrc = 2'd0;

    // R3 ripple add / subtract
    for (int k = 0; k < 10; k++) begin
      op_a = pa[k]; op_b = pb[k]; sub = 0;
      #2 expect_val("R3 add", 2, {1'b0, pa[k]} + {1'b0, pb[k]});
      sub = 1;
      #2 expect_val("R3 sub", 2, {1'b0, pa[k]} + {1'b0, ~pb[k]} + 9'd1);
    end

    #5;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule